// File: doc/BRIEF.md
# SMBus Register Access Command Engine

This engine sits behind a byte-level SMBus slave front end and turns the stream of bus events into register and nonvolatile-memory accesses. The front end reports start conditions (including repeated starts), stop conditions and every byte the master writes, including the address byte. It also asks for bytes to transmit. The engine answers each received byte with an ACK or NACK decision. When asked, it supplies the next byte to send.

The command byte that follows a write address is overloaded. A value in 0x00..0xDF selects a volatile register address. A value in 0xF8..0xFB is the high half of a nonvolatile address. Three reserved values start a block write (0xFC), a block read (0xFD) or a page erase (0xFE). The engine keeps one 16-bit access pointer and drives a simple memory port with a read address, write strobe, erase strobe, write address and write data. Nonvolatile byte programming and page erase take many cycles, and both durations are parameters. While a byte is being programmed, the engine holds the bus clock low. While an erase runs, it refuses its own address.

An optional packet error code (CRC-8, polynomial x^8+x^2+x+1, initial value 0, bits taken MSB first) covers every byte of a transaction, including the address bytes sent after a repeated start. The engine checks this code after writes and appends it after reads.

Top module: `smb_cmd_engine`

## Requirements
- R1: An address byte is accepted (ACK) only when its upper seven bits equal {5'b01111, addr_sel[1:0]}. Bit 0 is the direction (1 = read). Any other address is NACKed, and every further byte up to the next start or stop is NACKed and has no effect.
- R2: A command byte in 0x00..0xDF loads the pointer with that value. If one data byte follows, that byte is written to that address.
- R3: A command byte in 0xF8..0xFB, followed by a low byte, loads the pointer with {command, low}. A following data byte is written to that nonvolatile location.
- R4: A read transaction that is not a block read returns the byte at the current pointer as its first byte. The pointer is left unchanged.
- R5: Command 0xFC followed by a count of 1..32 accepts that many data bytes and writes them from the pointer upward, incrementing the pointer after each one. A count of 0, a count above 32, or a count whose last address would pass 0xFBFF is NACKed.
- R6: After command 0xFD and a repeated start with the read bit, the engine sends 0x20 and then 32 bytes read from the pointer upward.
- R7: Command bytes 0xE0..0xF7 and 0xFF are NACKed and have no effect.
- R8: With erase_en high and the pointer at or above 0xF800, command 0xFE erases the 32-byte page whose base is the pointer with its low five bits cleared. For ERASE_CYCLES cycles after that, the engine NACKs its own address.
- R9: With erase_en low, command 0xFE is acknowledged but erases nothing and starts no busy period.
- R10: Each nonvolatile byte write raises hold_scl for exactly PROG_CYCLES cycles, starting in the cycle the write strobe appears.
- R11: A byte received after the last expected byte of a write transaction is taken as a check code. It is ACKed only if it equals the CRC of all earlier bytes of the transaction. In a read, the byte requested after the last data byte is that CRC.
- R12: Every received byte produces ack_valid in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_sel | input | 2 | Address-select pins, low two address bits |
| erase_en | input | 1 | Page-erase enable flag |
| ev_start | input | 1 | Start or repeated-start pulse |
| ev_stop | input | 1 | Stop pulse |
| rx_valid | input | 1 | Received-byte strobe |
| rx_data | input | 8 | Received byte |
| ack_valid | output | 1 | Acknowledge decision valid |
| ack_ok | output | 1 | 1 = ACK, 0 = NACK |
| tx_req | input | 1 | Front end requests a byte to send |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| hold_scl | output | 1 | Request to stretch the bus clock |
| mem_raddr | output | 16 | Read address (current pointer) |
| mem_rdata | input | 8 | Read data for mem_raddr |
| mem_we | output | 1 | Byte write strobe |
| mem_erase | output | 1 | Page erase strobe |
| mem_waddr | output | 16 | Write or erase address |
| mem_wdata | output | 8 | Write data |

## Verification
The assertions check the following on every cycle:
- Each received byte is answered in the next cycle.
- No address byte is acknowledged while an erase is running.
- Erase strobes always carry a page-aligned nonvolatile address.
- No write goes past the top of the nonvolatile range.
- A nonvolatile write strobe always comes with the clock hold.
- The block-read count byte is always 0x20.

Some behaviour only the bench scenarios can show:
- Command decoding across the value ranges.
- Pointer reuse by a later receive.
- Block data order and pointer increment.
- Page contents before and after an erase, and an erase that is ignored.
- The exact length of the hold.
- Whether a given check code is right or wrong.

// File: rtl/smb_cmd_pkg.sv
package smb_cmd_pkg;

  localparam logic [15:0] NV_BASE = 16'hF800;
  localparam logic [15:0] NV_TOP  = 16'hFBFF;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_CMD, S_RDAT, S_NVLO, S_NVDAT,
    S_BCNT, S_BDAT, S_PEC, S_READ, S_SKIP
  } eng_st_t;

  typedef enum logic [2:0] {
    C_RAM, C_NVHI, C_BWR, C_BRD, C_ERASE, C_BAD
  } cmd_kind_t;

  function automatic cmd_kind_t classify(input logic [7:0] c);
    if (c <= 8'hDF)                    return C_RAM;
    else if (c >= 8'hF8 && c <= 8'hFB) return C_NVHI;
    else if (c == 8'hFC)               return C_BWR;
    else if (c == 8'hFD)               return C_BRD;
    else if (c == 8'hFE)               return C_ERASE;
    else                               return C_BAD;
  endfunction

  // CRC-8, poly 0x07, whole byte xored in then shifted eight times
  function automatic logic [7:0] crc8_next(input logic [7:0] crc, input logic [7:0] d);
    logic [7:0] c;
    c = crc ^ d;
    for (int i = 0; i < 8; i++)
      c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
    return c;
  endfunction

  // true when count is legal and the last written address stays in range
  function automatic logic blk_fits(input logic [15:0] ptr, input logic [7:0] cnt,
                                    input int unsigned max_cnt);
    logic [16:0] last;
    last = {1'b0, ptr} + {9'd0, cnt} - 17'd1;
    return (cnt != 8'd0) && (int'(cnt) <= max_cnt) && (last <= {1'b0, NV_TOP});
  endfunction

endpackage

// File: rtl/smb_busy_timer.sv
module smb_busy_timer #(
  parameter int unsigned CYCLES = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int unsigned CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= LOAD;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/smb_crc_acc.sv
module smb_crc_acc
  import smb_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       upd,
  input  logic [7:0] din,
  output logic [7:0] crc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc <= 8'h00;
    else if (clr) crc <= 8'h00;
    else if (upd) crc <= crc8_next(crc, din);
  end
endmodule

// File: rtl/smb_cmd_engine.sv
module smb_cmd_engine
  import smb_cmd_pkg::*;
#(
  parameter logic [4:0]  DEV_HI       = 5'b01111,
  parameter int unsigned BLK_MAX      = 32,
  parameter int unsigned PROG_CYCLES  = 12500,
  parameter int unsigned ERASE_CYCLES = 1000000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  addr_sel,
  input  logic        erase_en,
  input  logic        ev_start,
  input  logic        ev_stop,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  output logic        ack_valid,
  output logic        ack_ok,
  input  logic        tx_req,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        hold_scl,
  output logic [15:0] mem_raddr,
  input  logic [7:0]  mem_rdata,
  output logic        mem_we,
  output logic        mem_erase,
  output logic [15:0] mem_waddr,
  output logic [7:0]  mem_wdata
);
  localparam int unsigned IDX_W = $clog2(BLK_MAX + 3);
  localparam logic [IDX_W-1:0] IDX_PEC = IDX_W'(BLK_MAX + 1);
  localparam logic [7:0] BLK_CNT_BYTE = 8'(BLK_MAX);

  eng_st_t     st;
  logic [15:0] ptr;
  logic [7:0]  nv_hi;
  logic [7:0]  remain;
  logic        blk_pending, rd_blk;
  logic [IDX_W-1:0] rd_idx;
  logic [7:0]  crc, tx_next;
  logic        prog_busy, ers_busy;
  logic        sent_cnt_q;

  // named internal events
  cmd_kind_t kind;
  logic addr_hit, fresh_start, prog_start, erase_start, tx_is_cnt;

  assign kind        = classify(rx_data);
  assign addr_hit    = (rx_data[7:1] == {DEV_HI, addr_sel}) && !ers_busy;
  assign fresh_start = ev_start && (st == S_IDLE || st == S_SKIP);
  assign prog_start  = rx_valid && ((st == S_NVDAT) || (st == S_BDAT && ptr >= NV_BASE));
  assign erase_start = rx_valid && st == S_CMD && kind == C_ERASE && erase_en && ptr >= NV_BASE;
  assign tx_is_cnt   = (st == S_READ) && rd_blk && rd_idx == '0;
  assign mem_raddr   = ptr;
  assign hold_scl    = prog_busy;

  always_comb begin
    tx_next = 8'hFF;
    if (st == S_READ) begin
      if (rd_blk) begin
        if (rd_idx == '0)          tx_next = BLK_CNT_BYTE;
        else if (rd_idx < IDX_PEC) tx_next = mem_rdata;
        else if (rd_idx == IDX_PEC) tx_next = crc;
      end else begin
        if (rd_idx == '0)          tx_next = mem_rdata;
        else if (rd_idx == IDX_W'(1)) tx_next = crc;
      end
    end
  end

  smb_busy_timer #(.CYCLES(PROG_CYCLES)) u_prog (
    .clk(clk), .rst_n(rst_n), .start(prog_start), .busy(prog_busy));

  smb_busy_timer #(.CYCLES(ERASE_CYCLES)) u_erase (
    .clk(clk), .rst_n(rst_n), .start(erase_start), .busy(ers_busy));

  smb_crc_acc u_crc (
    .clk(clk), .rst_n(rst_n), .clr(fresh_start), .upd(rx_valid || tx_req),
    .din(rx_valid ? rx_data : tx_next), .crc(crc));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ptr <= '0; nv_hi <= '0; remain <= '0;
      blk_pending <= 1'b0; rd_blk <= 1'b0; rd_idx <= '0;
      ack_valid <= 1'b0; ack_ok <= 1'b0; tx_valid <= 1'b0; tx_data <= 8'hFF;
      mem_we <= 1'b0; mem_erase <= 1'b0; mem_waddr <= '0; mem_wdata <= '0;
      sent_cnt_q <= 1'b0;
    end else begin
      ack_valid <= 1'b0; tx_valid <= 1'b0; mem_we <= 1'b0; mem_erase <= 1'b0;
      sent_cnt_q <= 1'b0;
      if (ev_stop) begin
        st <= S_IDLE; blk_pending <= 1'b0;
      end else if (ev_start) begin
        st <= S_ADDR;
      end else if (rx_valid) begin
        ack_valid <= 1'b1;
        ack_ok    <= 1'b0;
        unique case (st)
          S_ADDR: begin
            if (addr_hit) begin
              ack_ok <= 1'b1;
              if (rx_data[0]) begin
                st <= S_READ; rd_blk <= blk_pending; rd_idx <= '0; blk_pending <= 1'b0;
              end else st <= S_CMD;
            end else st <= S_SKIP;
          end
          S_CMD: begin
            unique case (kind)
              C_RAM:   begin ptr <= {8'h00, rx_data}; ack_ok <= 1'b1; st <= S_RDAT; end
              C_NVHI:  begin nv_hi <= rx_data; ack_ok <= 1'b1; st <= S_NVLO; end
              C_BWR:   begin ack_ok <= 1'b1; st <= S_BCNT; end
              C_BRD:   begin ack_ok <= 1'b1; blk_pending <= 1'b1; st <= S_PEC; end
              C_ERASE: begin
                ack_ok <= 1'b1; st <= S_PEC;
                if (erase_start) begin
                  mem_erase <= 1'b1; mem_waddr <= {ptr[15:5], 5'd0};
                end
              end
              default: st <= S_SKIP;
            endcase
          end
          S_RDAT, S_NVDAT: begin
            mem_we <= 1'b1; mem_waddr <= ptr; mem_wdata <= rx_data;
            ack_ok <= 1'b1; st <= S_PEC;
          end
          S_NVLO: begin
            ptr <= {nv_hi, rx_data}; ack_ok <= 1'b1; st <= S_NVDAT;
          end
          S_BCNT: begin
            if (blk_fits(ptr, rx_data, BLK_MAX)) begin
              remain <= rx_data; ack_ok <= 1'b1; st <= S_BDAT;
            end else st <= S_SKIP;
          end
          S_BDAT: begin
            mem_we <= 1'b1; mem_waddr <= ptr; mem_wdata <= rx_data;
            ptr <= ptr + 16'd1; remain <= remain - 8'd1; ack_ok <= 1'b1;
            if (remain == 8'd1) st <= S_PEC;
          end
          S_PEC: begin
            ack_ok <= (rx_data == crc); st <= S_SKIP;
          end
          default: st <= S_SKIP;
        endcase
      end else if (tx_req) begin
        tx_valid   <= 1'b1;
        tx_data    <= tx_next;
        sent_cnt_q <= tx_is_cnt;
        if (st == S_READ) begin
          if (rd_blk && rd_idx != '0 && rd_idx < IDX_PEC) ptr <= ptr + 16'd1;
          if (rd_idx <= IDX_PEC) rd_idx <= rd_idx + 1'b1;
        end
      end
    end
  end

  // R12: each received byte gets a decision one cycle later
  a_r12_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !ev_start && !ev_stop) |=> ack_valid);

  // R8: no address acknowledged while the erase timer runs
  a_r8_nack_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !ev_start && !ev_stop && st == S_ADDR && ers_busy) |=> !ack_ok);

  // R8: erase strobe carries a page-aligned nonvolatile address
  a_r8_page_base: assert property (@(posedge clk) disable iff (!rst_n)
    mem_erase |-> (mem_waddr[4:0] == 5'd0 && mem_waddr >= NV_BASE));

  // R5: writes never pass the top of the nonvolatile range
  a_r5_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_waddr <= NV_TOP);

  // R10: a nonvolatile write strobe always comes with the clock hold
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_waddr >= NV_BASE) |-> hold_scl);

  // R6: the block-read count byte is fixed
  a_r6_count: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && sent_cnt_q) |-> tx_data == BLK_CNT_BYTE);
endmodule

// File: tb/smb_cmd_engine_test.sv
`timescale 1ns/1ps
module smb_cmd_engine_test;
  localparam int PROG = 20;
  localparam int ERS  = 60;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] addr_sel = 2'b10;
  logic erase_en = 1'b0, ev_start = 1'b0, ev_stop = 1'b0, rx_valid = 1'b0, tx_req = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic ack_valid, ack_ok, tx_valid, hold_scl, mem_we, mem_erase;
  logic [7:0] tx_data, mem_rdata, mem_wdata;
  logic [15:0] mem_raddr, mem_waddr;

  int applied = 0, bad = 0;
  logic [7:0] bcrc;
  logic [7:0] ram_m [256];
  logic [7:0] nv_m  [1024];

  localparam logic [7:0] AW = 8'h7C, AR = 8'h7D;

  always #10 clk = ~clk;

  smb_cmd_engine #(.PROG_CYCLES(PROG), .ERASE_CYCLES(ERS)) uut (
    .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .erase_en(erase_en),
    .ev_start(ev_start), .ev_stop(ev_stop), .rx_valid(rx_valid), .rx_data(rx_data),
    .ack_valid(ack_valid), .ack_ok(ack_ok), .tx_req(tx_req), .tx_valid(tx_valid),
    .tx_data(tx_data), .hold_scl(hold_scl), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
    .mem_we(mem_we), .mem_erase(mem_erase), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata));

  // memory model
  initial begin
    for (int i = 0; i < 256; i++) ram_m[i] = 8'(i) ^ 8'h5A;
    for (int i = 0; i < 1024; i++) nv_m[i] = 8'h00;
  end
  always @(posedge clk) begin
    if (mem_we) begin
      if (mem_waddr >= 16'hF800) nv_m[mem_waddr[9:0]] <= mem_wdata;
      else ram_m[mem_waddr[7:0]] <= mem_wdata;
    end
    if (mem_erase)
      for (int i = 0; i < 32; i++) nv_m[{mem_waddr[9:5], 5'(i)}] <= 8'hFF;
  end
  assign mem_rdata = (mem_raddr >= 16'hF800) ? nv_m[mem_raddr[9:0]] : ram_m[mem_raddr[7:0]];

  // bit-serial CRC-8, poly x^8+x^2+x+1
  function automatic logic [7:0] tcrc(input logic [7:0] c, input logic [7:0] d);
    logic fb;
    for (int i = 7; i >= 0; i--) begin
      fb = c[7] ^ d[i];
      c = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return c;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    applied++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  endtask

  task automatic start(input bit fresh);
    @(negedge clk); ev_start = 1'b1;
    @(negedge clk); ev_start = 1'b0;
    if (fresh) bcrc = 8'h00;
  endtask

  task automatic stop();
    @(negedge clk); ev_stop = 1'b1;
    @(negedge clk); ev_stop = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, output logic ack);
    while (hold_scl) @(negedge clk);
    @(negedge clk); rx_valid = 1'b1; rx_data = b;
    @(negedge clk); rx_valid = 1'b0;
    ack = ack_valid & ack_ok;
    bcrc = tcrc(bcrc, b);
  endtask

  task automatic recv(output logic [7:0] d);
    @(negedge clk); tx_req = 1'b1;
    @(negedge clk); tx_req = 1'b0;
    d = tx_data;
    bcrc = tcrc(bcrc, d);
  endtask

  task automatic set_ptr_nv(input logic [15:0] a);
    logic k;
    start(1); send(AW, k); send(a[15:8], k); send(a[7:0], k); stop();
  endtask

  task automatic read_at(input logic [15:0] a, output logic [7:0] d);
    logic k;
    if (a >= 16'hF800) set_ptr_nv(a);
    else begin start(1); send(AW, k); send(a[7:0], k); stop(); end
    start(1); send(AR, k); recv(d); stop();
  endtask

  task automatic t_reset();
    chk("R12 reset ack_valid", ack_valid, 0);
    chk("R10 reset hold", hold_scl, 0);
    chk("R5 reset mem_we", mem_we, 0);
  endtask

  task automatic t_address();
    logic k; logic [7:0] d;
    start(1); send(8'h7A, k); chk("R1 foreign address NACK", k, 0);
    send(8'h10, k); chk("R1 ignored byte NACK", k, 0);
    send(8'h99, k); stop();
    start(1); send(AW, k); chk("R1 own address ACK", k, 1);
    chk("R12 ack_valid after byte", ack_valid, 1); stop();
    read_at(16'h0010, d); chk("R1 ignored write had no effect", d, 8'h10 ^ 8'h5A);
  endtask

  task automatic t_ram();
    logic k; logic [7:0] d;
    start(1); send(AW, k); send(8'h10, k); chk("R2 ram cmd ACK", k, 1);
    send(8'hA5, k); chk("R2 ram data ACK", k, 1); stop();
    read_at(16'h0010, d); chk("R2/R4 ram readback", d, 8'hA5);
    start(1); send(AR, k); recv(d); chk("R4 pointer unchanged", d, 8'hA5); stop();
  endtask

  task automatic t_nv();
    logic k; logic [7:0] d; int n;
    start(1); send(AW, k); send(8'hF9, k); send(8'h23, k); send(8'h5C, k);
    chk("R3 nv data ACK", k, 1);
    n = 0;
    while (hold_scl) begin n++; @(negedge clk); end
    chk("R10 hold length", n, PROG);
    stop();
    read_at(16'hF923, d); chk("R3 nv readback", d, 8'h5C);
  endtask

  task automatic t_reserved();
    logic k;
    start(1); send(AW, k); send(8'hE5, k); chk("R7 reserved E5 NACK", k, 0); stop();
    start(1); send(AW, k); send(8'hFF, k); chk("R7 reserved FF NACK", k, 0); stop();
  endtask

  task automatic t_block();
    logic k; logic [7:0] d;
    start(1); send(AW, k); send(8'h40, k); stop();
    start(1); send(AW, k); send(8'hFC, k); send(8'd0, k); chk("R5 count 0 NACK", k, 0); stop();
    start(1); send(AW, k); send(8'hFC, k); send(8'd33, k); chk("R5 count 33 NACK", k, 0); stop();
    start(1); send(AW, k); send(8'hFC, k); send(8'd3, k); chk("R5 count 3 ACK", k, 1);
    send(8'h11, k); send(8'h22, k); send(8'h33, k); chk("R5 last data ACK", k, 1);
    send(bcrc, k); chk("R11 block write PEC ACK", k, 1); stop();
    // block read from 0x40
    start(1); send(AW, k); send(8'h40, k); stop();
    start(1); send(AW, k); send(8'hFD, k); chk("R6 block read cmd ACK", k, 1);
    start(0); send(AR, k); chk("R6 read address ACK", k, 1);
    recv(d); chk("R6 count byte", d, 8'h20);
    for (int i = 0; i < 32; i++) begin
      logic [7:0] e;
      recv(d);
      e = (i == 0) ? 8'h11 : (i == 1) ? 8'h22 : (i == 2) ? 8'h33 : 8'(8'h40 + i) ^ 8'h5A;
      chk($sformatf("R6 block byte %0d", i), d, e);
    end
    begin logic [7:0] exp_pec; exp_pec = bcrc; recv(d);
      chk("R11 block read PEC", d, exp_pec); end
    stop();
  endtask

  task automatic t_block_nv();
    logic k; logic [7:0] d;
    set_ptr_nv(16'hFBF0);
    start(1); send(AW, k); send(8'hFC, k); send(8'd17, k); chk("R5 past top NACK", k, 0); stop();
    start(1); send(AW, k); send(8'hFC, k); send(8'd16, k); chk("R5 up to top ACK", k, 1);
    for (int i = 0; i < 16; i++) begin
      send(8'(8'h80 + i), k);
      chk("R10 hold after block nv byte", hold_scl, 1);
    end
    stop();
    read_at(16'hFBFF, d); chk("R5 last nv block byte", d, 8'h8F);
    read_at(16'hFBF0, d); chk("R5 first nv block byte", d, 8'h80);
  endtask

  task automatic t_erase();
    logic k; logic [7:0] d;
    erase_en = 1'b0;
    set_ptr_nv(16'hF845);
    start(1); send(AW, k); send(8'hFE, k); chk("R9 disabled erase ACK", k, 1); stop();
    start(1); send(AW, k); chk("R9 no busy period", k, 1); stop();
    read_at(16'hF845, d); chk("R9 page untouched", d, 8'h00);
    erase_en = 1'b1;
    set_ptr_nv(16'hF847);
    start(1); send(AW, k); send(8'hFE, k); chk("R8 erase cmd ACK", k, 1); stop();
    start(1); send(AW, k); chk("R8 NACK while erasing", k, 0); stop();
    repeat (ERS + 4) @(negedge clk);
    start(1); send(AW, k); chk("R8 ACK after erase", k, 1); stop();
    read_at(16'hF840, d); chk("R8 page base erased", d, 8'hFF);
    read_at(16'hF85F, d); chk("R8 page end erased", d, 8'hFF);
    read_at(16'hF860, d); chk("R8 next page kept", d, 8'h00);
    erase_en = 1'b0;
  endtask

  task automatic t_pec();
    logic k; logic [7:0] d, p;
    start(1); send(AW, k); send(8'h20, k); send(8'h77, k);
    send(bcrc, k); chk("R11 correct PEC ACK", k, 1); stop();
    start(1); send(AW, k); send(8'h21, k); send(8'h66, k);
    send(bcrc ^ 8'h01, k); chk("R11 wrong PEC NACK", k, 0); stop();
    start(1); send(AW, k); send(8'h20, k); stop();
    start(1); send(AR, k); recv(d); chk("R4 receive byte", d, 8'h77);
    p = bcrc; recv(d); chk("R11 receive PEC", d, p); stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    bcrc = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_address();
    t_ram();
    t_nv();
    t_reserved();
    t_block();
    t_block_nv();
    t_erase();
    t_pec();
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule